// File: doc/BRIEF.md
# Indirect Pattern RAM Access Controller

This block puts a 128-word by 40-bit pattern RAM behind three 16-bit host registers, here called the control register (A), the low data register (B) and the high data register (C). The host selects a word address and supplies the top byte of the word in A. It then supplies the four remaining bytes in B and C. The whole 40-bit word is written into the RAM in a single cycle, on the write to C, and only if that write completes an A, B, C sequence. After A has been written with the mode bit clear, the host can read the addressed word back through the same three registers, in any order.

Bit 7 of A is the match-mode bit. Writing A with that bit set gives the RAM to the pattern matcher. The matcher reads words through its own address port. While match mode is on, the host cannot write the RAM, writes to B and C are discarded, and register reads show only the mode bit. Writing A with bit 7 clear returns the RAM to the host.

Top module: `pat_ram_front`

## Requirements
- R1: After hard reset (rstN low) the mode bit reads 0 and the word address is 0, so a read of A returns 0x00 in bits 7:0.
- R2: A host write to A (regSel=0) with bit 7 = 0 loads the word address from bits 6:0. A later read of A returns {RAM byte 4 of that word, 1'b0, address}.
- R3: A write to A, then to B (regSel=1), then to C (regSel=2) stores the 40-bit word {A[15:8], C[15:8], C[7:0], B[15:8], B[7:0]} at the address, with B[7:0] as byte 0. The store happens on the C write.
- R4: In mode 0, register reads return the addressed RAM word: B returns bits 15:0, C returns bits 31:16 and A returns bits 39:32 in its upper byte. Reads may come in any order. rdData is updated on the clock edge that samples regRd.
- R5: The RAM is not modified by writes to A or B alone. A sequence left unfinished leaves the stored word unchanged.
- R6: A write to C that does not directly complete A-then-B is dropped. This covers a write to C right after A, and a write to C after a repeated write to B. Every write to A restarts the sequence.
- R7: A write to A with bit 7 = 1 enters match mode.
- R8: In match mode, writes to B and C and bits other than bit 7 of an A write have no effect on the RAM or on the word address.
- R9: In match mode, a read of A returns 0x0080, and reads of B or C return 0x0000.
- R10: In match mode, mtchData shows, without a clock delay, the RAM word at mtchAddr. In mode 0, mtchData is 0.
- R11: A hard reset taken in match mode returns the block to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| regSel | input | 2 | Register select: 0 = A, 1 = B, 2 = C |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data, registered |
| mtchAddr | input | 7 | Matcher word address |
| mtchData | output | 40 | Matcher read data |

## Verification
On every cycle, assertions check four things. No RAM store or B staging happens in match mode. The word address stays fixed while in match mode unless A is written with the mode bit clear. Register reads in match mode leave every bit except bit 7 at zero. A write to A with bit 7 set always switches the mode on. Only the bench scenarios can show the remaining behaviour: the byte placement of a committed word, that interrupted or out-of-order sequences leave the stored word intact, reads in any order, the matcher port contents, and recovery from reset.

// File: rtl/pat_ram_pkg.sv
package pat_ram_pkg;
  localparam int REG_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 5 * BYTE_W;
  localparam int MODE_BIT = 7;

  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_C = 2'd2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_GOT_A = 2'd1,
    SEQ_GOT_B = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic commit;
  } ctrlStrb_t;
endpackage

// File: rtl/pat_ram_ctrl.sv
module pat_ram_ctrl
  import pat_ram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       regWr,
  input  logic       wrModeBit,
  output ctrlStrb_t  strb,
  output logic       modeQ
);
  seqState_t seqQ;
  logic wrA, wrB, wrC;

  always_comb begin
    wrA = regWr && (regSel == SEL_A);
    wrB = regWr && (regSel == SEL_B);
    wrC = regWr && (regSel == SEL_C);
    strb.loadA  = wrA && !wrModeBit;
    strb.loadB  = wrB && !modeQ && (seqQ == SEQ_GOT_A);
    strb.commit = wrC && !modeQ && (seqQ == SEQ_GOT_B);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b0;
    end else if (wrA) begin
      modeQ <= wrModeBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ <= SEQ_IDLE;
    end else if (wrA) begin
      seqQ <= wrModeBit ? SEQ_IDLE : SEQ_GOT_A;
    end else if (wrB && !modeQ) begin
      seqQ <= (seqQ == SEQ_GOT_A) ? SEQ_GOT_B : SEQ_IDLE;
    end else if (wrC && !modeQ) begin
      seqQ <= SEQ_IDLE;
    end
  end

  // R7
  modeSet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == SEL_A && wrModeBit) |=> modeQ);
endmodule

// File: rtl/pat_ram_dp.sv
module pat_ram_dp
  import pat_ram_pkg::*;
#(
  parameter int AddrW = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              modeIn,
  input  logic [1:0]        regSel,
  input  logic              regRd,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [AddrW-1:0]  mtchAddr,
  output logic [WORD_W-1:0] mtchData
);
  localparam int Depth = 2 ** AddrW;
  localparam logic [REG_W-1:0] ModeView = REG_W'(1) << MODE_BIT;

  logic [AddrW-1:0]  addrQ;
  logic [BYTE_W-1:0] stageHi;
  logic [REG_W-1:0]  stageLo;
  logic [WORD_W-1:0] ram [Depth];
  logic [WORD_W-1:0] ramRd;
  logic [REG_W-1:0]  aView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      stageHi <= '0;
      stageLo <= '0;
    end else begin
      if (strb.loadA) begin
        addrQ   <= wrData[AddrW-1:0];
        stageHi <= wrData[REG_W-1:BYTE_W];
      end
      if (strb.loadB) begin
        stageLo <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      ram[addrQ] <= {stageHi, wrData, stageLo};
    end
  end

  always_comb begin
    ramRd = ram[addrQ];
    aView = '0;
    aView[REG_W-1:BYTE_W] = ramRd[WORD_W-1:WORD_W-BYTE_W];
    aView[AddrW-1:0] = addrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (regRd) begin
      case (regSel)
        SEL_A:   rdData <= modeIn ? ModeView : aView;
        SEL_B:   rdData <= modeIn ? '0 : ramRd[REG_W-1:0];
        SEL_C:   rdData <= modeIn ? '0 : ramRd[2*REG_W-1:REG_W];
        default: rdData <= '0;
      endcase
    end
  end

  assign mtchData = modeIn ? ram[mtchAddr] : '0;

  // R8
  noHostStore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit || strb.loadB) |-> !modeIn);

  // R8
  addrHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn && !strb.loadA) |=> $stable(addrQ));

  // R9
  maskedRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && modeIn) |=> ((rdData & ~ModeView) == '0));
endmodule

// File: rtl/pat_ram_front.sv
module pat_ram_front
  import pat_ram_pkg::*;
#(
  parameter int AddrW = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [AddrW-1:0]  mtchAddr,
  output logic [WORD_W-1:0] mtchData
);
  ctrlStrb_t strb;
  logic      modeQ;

  pat_ram_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .regWr     (regWr),
    .wrModeBit (wrData[MODE_BIT]),
    .strb      (strb),
    .modeQ     (modeQ)
  );

  pat_ram_dp #(.AddrW(AddrW)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeIn   (modeQ),
    .regSel   (regSel),
    .regRd    (regRd),
    .wrData   (wrData),
    .rdData   (rdData),
    .mtchAddr (mtchAddr),
    .mtchData (mtchData)
  );
endmodule

// File: tb/test_pat_ram_front.sv
module test_pat_ram_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [6:0]  mtchAddr = '0;
  logic [39:0] mtchData;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] expQ [$];
  logic [15:0] maskQ [$];
  string       reqQ [$];
  logic        rdPend = 1'b0;

  always #2 clk = ~clk;

  pat_ram_front i_pat_ram_front (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .mtchAddr(mtchAddr), .mtchData(mtchData)
  );

  task automatic hardReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic regWrite(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    regSel = s; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] s, input logic [15:0] e,
                         input logic [15:0] m, input string req);
    @(negedge clk);
    regSel = s; regRd = 1'b1;
    expQ.push_back(e); maskQ.push_back(m); reqQ.push_back(req);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic checkMatch(input logic [6:0] a, input logic [39:0] e, input string req);
    @(negedge clk);
    mtchAddr = a;
    #1;
    nChecks++;
    if (mtchData !== e) begin
      nFails++;
      $display("FAIL %s matcher addr %0d: actual %h expected %h", req, a, mtchData, e);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rdPend <= regRd;

  always @(negedge clk) begin
    if (rdPend && expQ.size() > 0) begin
      logic [15:0] e, m;
      string r;
      e = expQ.pop_front(); m = maskQ.pop_front(); r = reqQ.pop_front();
      nChecks++;
      if ((rdData & m) !== (e & m)) begin
        nFails++;
        $display("FAIL %s read: actual %h expected %h (mask %h)", r, rdData & m, e & m, m);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    hardReset();
    // R1 reset state
    regRead(2'd0, 16'h0000, 16'h00FF, "R1");
    checkMatch(7'd5, 40'h0, "R1");

    // R2 R3 R4: commit at 5, read back C, A, B
    regWrite(2'd0, 16'h5A05);
    regWrite(2'd1, 16'h1122);
    regWrite(2'd2, 16'h3344);
    regRead(2'd2, 16'h3344, 16'hFFFF, "R4");
    regRead(2'd0, 16'h5A05, 16'hFFFF, "R2");
    regRead(2'd1, 16'h1122, 16'hFFFF, "R3");

    // R3 R4: commit at 127, read B, A, C
    regWrite(2'd0, 16'hC37F);
    regWrite(2'd1, 16'hBEEF);
    regWrite(2'd2, 16'hCAFE);
    regRead(2'd1, 16'hBEEF, 16'hFFFF, "R3");
    regRead(2'd0, 16'hC37F, 16'hFFFF, "R4");
    regRead(2'd2, 16'hCAFE, 16'hFFFF, "R3");

    // R5: A, B then restart with A; nothing stored
    regWrite(2'd0, 16'h7705);
    regWrite(2'd1, 16'h9999);
    regWrite(2'd0, 16'h0105);
    regRead(2'd1, 16'h1122, 16'hFFFF, "R5");
    regRead(2'd0, 16'h5A05, 16'hFFFF, "R5");
    // R6: C right after A dropped
    regWrite(2'd2, 16'h5555);
    regRead(2'd2, 16'h3344, 16'hFFFF, "R6");
    // R6: A, B, B, C dropped
    regWrite(2'd0, 16'h6605);
    regWrite(2'd1, 16'hAAAA);
    regWrite(2'd1, 16'hBBBB);
    regWrite(2'd2, 16'hCCCC);
    regRead(2'd1, 16'h1122, 16'hFFFF, "R6");
    regRead(2'd2, 16'h3344, 16'hFFFF, "R6");
    regRead(2'd0, 16'h5A05, 16'hFFFF, "R6");
    checkMatch(7'd5, 40'h0, "R10");

    // R7 R9 R10: match mode
    regWrite(2'd0, 16'h0080);
    regRead(2'd0, 16'h0080, 16'hFFFF, "R9");
    regRead(2'd1, 16'h0000, 16'hFFFF, "R9");
    regRead(2'd2, 16'h0000, 16'hFFFF, "R9");
    checkMatch(7'd5, 40'h5A33441122, "R7");
    checkMatch(7'd127, 40'hC3CAFEBEEF, "R10");

    // R8: writes in match mode ignored
    regWrite(2'd1, 16'hDEAD);
    regWrite(2'd2, 16'hF00D);
    regWrite(2'd0, 16'hFF85);
    regWrite(2'd2, 16'h1234);
    checkMatch(7'd5, 40'h5A33441122, "R8");
    checkMatch(7'd127, 40'hC3CAFEBEEF, "R8");
    regWrite(2'd0, 16'h0005);
    checkMatch(7'd5, 40'h0, "R10");
    regRead(2'd1, 16'h1122, 16'hFFFF, "R8");
    regRead(2'd2, 16'h3344, 16'hFFFF, "R8");
    regRead(2'd0, 16'h5A05, 16'hFFFF, "R8");

    // R11: reset out of match mode
    regWrite(2'd0, 16'h0080);
    hardReset();
    regRead(2'd0, 16'h0000, 16'h00FF, "R11");
    checkMatch(7'd127, 40'h0, "R11");
    regWrite(2'd0, 16'h9100);
    regWrite(2'd1, 16'h0102);
    regWrite(2'd2, 16'h0304);
    regRead(2'd0, 16'h9100, 16'hFFFF, "R11");
    regRead(2'd2, 16'h0304, 16'hFFFF, "R3");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule